// File: doc/BRIEF.md
# Three-Channel Complementary PWM Timer

This block generates pulse-width modulated waveforms on three channels from one 10-bit counter. The counter steps on a prescaled tick. The tick is the input clock divided by a power of two, or a tick supplied by a neighbouring timer. The counter runs in one of two modes. In edge-aligned mode it counts up and wraps to zero after the period value. In centre-aligned mode it counts up to the period value and then back down to zero.

Each channel compares the counter with its own duty value. It drives a primary output and a complementary secondary output. A programmable dead time holds back every rising edge, so the two outputs of a pair are never high at the same time. The block raises pulse interrupts when a channel's counter value equals its duty value, and when the counter reaches its bottom. Software sets up the block through byte-wide register writes. Period and duty writes go to shadow copies. These copies take effect only at the bottom of a cycle, or while the counter is stopped.

Top module: `pwm3_timer`

## Requirements
- R1: During and after reset, the counter output is 0. All primary outputs, secondary outputs and interrupt outputs are 0.
- R2: The control register is at address 0. Bit 0 is the run bit. Bit 1 selects centre-aligned mode. Bits 7:4 are the clock-select code. Codes 0 to 14 step the counter once every 2^code input clocks, counted from the write that set the run bit. Code 15 steps it once per clock in which `ext_tick` is high.
- R3: In edge-aligned mode the counter counts 0, 1, ... up to the period value, and then wraps to 0. With a period of 0 the counter stays at 0.
- R4: In centre-aligned mode the counter counts up from 0 to the period value. It then counts down to 0 and turns up again, so one cycle lasts 2×period ticks.
- R5: While running with zero dead time, primary output i is high exactly when the counter was below duty i one clock earlier. Secondary output i is the inverse of primary output i. While stopped, both outputs of every pair are low.
- R6: The dead-time register (address 1, bits 3:0) delays each rising edge of each output by that many ticks. It adds nothing to falling edges. The two outputs of a pair are never high together.
- R7: Period (addresses 4 and 5) and duty values (channel i at addresses 6+2i and 7+2i) are written low byte then high byte (bits 1:0). A write made while the counter is running takes effect only at the next bottom event.
- R8: The interrupt-enable register is at address 2. Its bits 2:0 gate the channel match interrupts. `irq_match[i]` is high for one clock right after the counter steps onto the value of duty i, if enable bit i is set.
- R9: When enable bit 3 is set, `irq_bottom` is high for one clock right after a bottom event. In edge-aligned mode the bottom event is the wrap to 0. In centre-aligned mode it is reaching 0 while counting down.
- R10: Clearing the run bit returns the counter to 0 one clock after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock (fx) |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_tick | input | 1 | Tick from the neighbouring timer, used with clock-select code 15 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data byte |
| cnt_value | output | 10 | Current counter value |
| pwm_pri | output | 3 | Primary outputs, bit i for channel i |
| pwm_sec | output | 3 | Complementary secondary outputs |
| irq_match | output | 3 | Per-channel match interrupt pulses |
| irq_bottom | output | 1 | Bottom-event interrupt pulse |

## Verification
Faults in the counter or the prescaler show at once on `cnt_value` and shift the bottom and match pulses within one period. A wrong direction bit breaks the triangle at the first reversal. A stale active period or duty copy is invisible until the cycle after a bottom event. For that reason the bench checks the counter both before and after the wrap that follows a mid-cycle write. A dead-band counter that fails to clear or to saturate moves the delayed rising edge by whole ticks. The bench checks the edge on both sides of the expected clock.

// File: rtl/pwm3_pkg.sv
// Shared register addresses and the control register layout for the
// three-channel PWM timer. Assumes a 4-bit byte-address register space.
package pwm3_pkg;

    localparam logic [3:0] ADDR_CTRL    = 4'd0;
    localparam logic [3:0] ADDR_DEAD    = 4'd1;
    localparam logic [3:0] ADDR_IEN     = 4'd2;
    localparam logic [3:0] ADDR_PER_LO  = 4'd4;
    localparam logic [3:0] ADDR_PER_HI  = 4'd5;
    localparam logic [3:0] ADDR_DUTY_LO = 4'd6;  // channel i low byte at 6+2i

    typedef struct packed {
        logic [3:0] clk_sel;
        logic [1:0] spare;
        logic       centre;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/pwm3_prescaler.sv
// Tick generator: a free-running divider cleared while stopped. Code k below
// the top code yields one tick every 2^k clocks; the top code passes the
// external tick through. Assumes PRE_W == 2^SEL_W - 2.
module pwm3_prescaler #(
    parameter int SEL_W = 4,
    parameter int PRE_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_tick,
    output logic             tick
);
    localparam logic [SEL_W-1:0] EXT_CODE = SEL_W'((1 << SEL_W) - 1);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;

    // Divider counts only while running, restarts from zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + PRE_W'(1);
    end

    // Tick fires when the low sel bits of the divider are all ones.
    always_comb begin
        one_hot = (PRE_W+1)'(1) << sel;
        mask    = one_hot[PRE_W-1:0] - PRE_W'(1);
        if (!run)                 tick = 1'b0;
        else if (sel == EXT_CODE) tick = ext_tick;
        else                      tick = ((div_q & mask) == mask);
    end

endmodule

// File: rtl/pwm3_counter.sv
// Period counter with edge-aligned (wrap) and centre-aligned (up/down)
// modes. Raises a combinational bottom event on the tick that brings the
// counter to its bottom. Assumes the period only changes at a bottom event.
module pwm3_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             centre,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             bottom_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic             up_q;

    // Step the counter on each tick according to the mode and direction.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            if (period == '0) begin
                cnt_q <= '0;
                up_q  <= 1'b1;
            end else if (!centre) begin
                cnt_q <= (cnt_q >= period) ? '0 : cnt_q + CNT_W'(1);
                up_q  <= 1'b1;
            end else if (up_q) begin
                if (cnt_q >= period) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    up_q  <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end else if (cnt_q <= CNT_W'(1)) begin
                cnt_q <= '0;
                up_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Bottom event: wrap in edge mode, arrival at zero going down in centre mode.
    always_comb begin
        bottom_evt = run && tick &&
                     ((period == '0) ||
                      (!centre && cnt_q >= period) ||
                      (centre && !up_q && cnt_q <= CNT_W'(1)));
    end

    assign cnt = cnt_q;

    // R3/R4: counter never passes the active period.
    a_r3_within_period: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= period);

    // R2: a running counter without a tick holds its value.
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt_q));

    // R10: a stopped counter returns to zero on the next clock.
    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/pwm3_deadband.sv
// Dead-band stage for one complementary pair. Each leg's rising edge waits
// until its raw request has been high for `dead` ticks; falling edges are
// taken on the next clock. Assumes the two raw requests are never both high.
module pwm3_deadband #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [DT_W-1:0] dead,
    input  logic            raw_pri,
    input  logic            raw_sec,
    output logic            out_pri,
    output logic            out_sec
);
    logic [1:0] raw;
    logic [1:0] out_q;

    assign raw = {raw_sec, raw_pri};

    for (genvar g = 0; g < 2; g++) begin : g_leg
        logic [DT_W-1:0] wait_q;

        // Count ticks of a held request; release the output once the count reaches the dead time.
        always_ff @(posedge clk) begin
            if (!rst_n || !raw[g]) begin
                wait_q   <= '0;
                out_q[g] <= 1'b0;
            end else if (wait_q >= dead) begin
                out_q[g] <= 1'b1;
            end else if (tick) begin
                wait_q <= wait_q + DT_W'(1);
            end
        end
    end

    assign out_pri = out_q[0];
    assign out_sec = out_q[1];

    // R6: the two legs of a pair are never high together.
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_q));

    // R6: an output only rises while its request is still present.
    a_r6_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q[0]) |-> $past(raw[0]));

endmodule

// File: rtl/pwm3_timer.sv
// Three-channel complementary PWM timer top. Holds the byte-written
// registers with shadow/active copies, the duty comparators and the
// interrupt pulses, and instantiates prescaler, counter and dead-band stages.
// Assumes 8 < CNT_W <= 16 and register writes of one byte per clock.
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int NCH   = 3,
    parameter int DT_W  = 4,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_tick,
    input  logic             bus_wr,
    input  logic [3:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [CNT_W-1:0] cnt_value,
    output logic [NCH-1:0]   pwm_pri,
    output logic [NCH-1:0]   pwm_sec,
    output logic [NCH-1:0]   irq_match,
    output logic             irq_bottom
);
    localparam int HI_W  = CNT_W - 8;
    localparam int PRE_W = (1 << SEL_W) - 2;

    ctrl_t            ctrl_q;
    logic [DT_W-1:0]  dead_q;
    logic [NCH:0]     ien_q;
    logic [CNT_W-1:0] per_sh_q, per_act_q;
    logic [CNT_W-1:0] duty_sh_q  [NCH];
    logic [CNT_W-1:0] duty_act_q [NCH];
    logic             tick, bottom_evt, load_act;
    logic             stepped_q, bottom_q;
    logic [CNT_W-1:0] cnt;

    // Control, dead-time, enable and period shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            dead_q   <= '0;
            ien_q    <= '0;
            per_sh_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL:   ctrl_q               <= ctrl_t'(bus_wdata);
                ADDR_DEAD:   dead_q               <= bus_wdata[DT_W-1:0];
                ADDR_IEN:    ien_q                <= bus_wdata[NCH:0];
                ADDR_PER_LO: per_sh_q[7:0]        <= bus_wdata;
                ADDR_PER_HI: per_sh_q[CNT_W-1:8]  <= bus_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // Active copies follow shadows while stopped or at a bottom event.
    assign load_act = !ctrl_q.run || bottom_evt;

    // Active period register.
    always_ff @(posedge clk) begin
        if (!rst_n)        per_act_q <= '0;
        else if (load_act) per_act_q <= per_sh_q;
    end

    pwm3_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.run),
        .sel      (ctrl_q.clk_sel),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    pwm3_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q.run),
        .centre     (ctrl_q.centre),
        .tick       (tick),
        .period     (per_act_q),
        .cnt        (cnt),
        .bottom_evt (bottom_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [3:0] LO_ADDR = ADDR_DUTY_LO + 4'(2 * c);
        localparam logic [3:0] HI_ADDR = LO_ADDR + 4'd1;
        logic raw_pri, raw_sec;

        // Duty shadow register for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                duty_sh_q[c] <= '0;
            end else if (bus_wr && bus_addr == LO_ADDR) begin
                duty_sh_q[c][7:0] <= bus_wdata;
            end else if (bus_wr && bus_addr == HI_ADDR) begin
                duty_sh_q[c][CNT_W-1:8] <= bus_wdata[HI_W-1:0];
            end
        end

        // Duty active register, reloaded with the period.
        always_ff @(posedge clk) begin
            if (!rst_n)        duty_act_q[c] <= '0;
            else if (load_act) duty_act_q[c] <= duty_sh_q[c];
        end

        // Comparator: primary request below duty, secondary otherwise, none when stopped.
        always_comb begin
            raw_pri = ctrl_q.run && (cnt < duty_act_q[c]);
            raw_sec = ctrl_q.run && !(cnt < duty_act_q[c]);
        end

        pwm3_deadband #(.DT_W(DT_W)) u_db (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .dead    (dead_q),
            .raw_pri (raw_pri),
            .raw_sec (raw_sec),
            .out_pri (pwm_pri[c]),
            .out_sec (pwm_sec[c])
        );

        // Match pulse for the clock after the counter steps onto duty.
        assign irq_match[c] = ien_q[c] && stepped_q && (cnt == duty_act_q[c]);
    end

    // Flags of the previous clock: counter step and bottom event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stepped_q <= 1'b0;
            bottom_q  <= 1'b0;
        end else begin
            stepped_q <= tick;
            bottom_q  <= bottom_evt;
        end
    end

    assign irq_bottom = ien_q[NCH] && bottom_q;
    assign cnt_value  = cnt;

    // R9: a bottom event always leaves the counter at zero.
    a_r9_bottom_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_q |-> (cnt == '0));

    // R7: while running, the active period only changes at a bottom event.
    a_r7_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.run && !bottom_evt) |=> $stable(per_act_q));

    // R5: a stopped block drives all primaries low on the next clock.
    a_r5_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |=> (pwm_pri == '0 && pwm_sec == '0));

    // R8: match pulses only appear when the counter has just stepped.
    a_r8_match_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_match != '0) |-> stepped_q);

endmodule

// File: tb/pwm3_timer_test.sv
// Self-checking bench: a vector table of counter and output snapshots,
// followed by directed tests for reset, dead time, reload, interrupts,
// the external tick and stopping.
module pwm3_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [9:0] cnt_value;
    logic [2:0] pwm_pri, pwm_sec, irq_match;
    logic       irq_bottom;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm3_timer uut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_value(cnt_value),
        .pwm_pri(pwm_pri), .pwm_sec(pwm_sec), .irq_match(irq_match),
        .irq_bottom(irq_bottom)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic       centre;
        logic [9:0] per;
        logic [9:0] da;
        logic [9:0] db;
        logic [9:0] dc;
        logic [7:0] edges;
        logic [9:0] e_cnt;
        logic [2:0] e_pri;
        logic [2:0] e_sec;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{4'd0, 1'b0, 10'd9, 10'd3, 10'd5, 10'd0, 8'd4,  10'd4, 3'b010, 3'b101},
        '{4'd0, 1'b0, 10'd9, 10'd3, 10'd5, 10'd0, 8'd12, 10'd2, 3'b011, 3'b100},
        '{4'd0, 1'b1, 10'd6, 10'd2, 10'd4, 10'd7, 8'd9,  10'd3, 3'b100, 3'b011},
        '{4'd2, 1'b0, 10'd5, 10'd1, 10'd3, 10'd6, 8'd13, 10'd3, 3'b100, 3'b011},
        '{4'd1, 1'b1, 10'd3, 10'd2, 10'd0, 10'd3, 8'd15, 10'd1, 3'b101, 3'b010},
        '{4'd0, 1'b0, 10'd0, 10'd1, 10'd0, 10'd0, 8'd5,  10'd0, 3'b001, 3'b110}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ext_tick = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input logic [9:0] per, input logic [9:0] da,
                         input logic [9:0] db, input logic [9:0] dc,
                         input logic [3:0] dead, input logic [3:0] ien);
        wr(4'd1, {4'd0, dead});
        wr(4'd2, {4'd0, ien});
        wr(4'd4, per[7:0]);  wr(4'd5, {6'd0, per[9:8]});
        wr(4'd6, da[7:0]);   wr(4'd7, {6'd0, da[9:8]});
        wr(4'd8, db[7:0]);   wr(4'd9, {6'd0, db[9:8]});
        wr(4'd10, dc[7:0]);  wr(4'd11, {6'd0, dc[9:8]});
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 cnt", 16'(cnt_value), 16'd0);
        chk("R1 pri/sec", 16'({pwm_pri, pwm_sec}), 16'd0);
        chk("R1 irq", 16'({irq_match, irq_bottom}), 16'd0);

        // Table walk: R2 clock select, R3 edge mode, R4 centre mode, R5 outputs
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            setup(VEC[i].per, VEC[i].da, VEC[i].db, VEC[i].dc, 4'd0, 4'd0);
            wr(4'd0, {VEC[i].sel, 2'b00, VEC[i].centre, 1'b1});
            wait_edges(int'(VEC[i].edges));
            chk(VEC[i].centre ? "R4 cnt" : "R3 cnt", 16'(cnt_value), 16'(VEC[i].e_cnt));
            chk("R5 pri", 16'(pwm_pri), 16'(VEC[i].e_pri));
            chk("R5 sec", 16'(pwm_sec), 16'(VEC[i].e_sec));
        end

        // R6: dead time of 3 ticks delays both rising edges of channel A
        do_reset();
        setup(10'd9, 10'd5, 10'd0, 10'd0, 4'd3, 4'd0);
        wr(4'd0, 8'h01);
        wait_edges(3);
        chk("R6 pri held", 16'(pwm_pri[0]), 16'd0);
        wait_edges(1);
        chk("R6 pri rise", 16'(pwm_pri[0]), 16'd1);
        wait_edges(2);
        chk("R6 gap", 16'({pwm_pri[0], pwm_sec[0]}), 16'd0);
        wait_edges(2);
        chk("R6 sec held", 16'(pwm_sec[0]), 16'd0);
        wait_edges(1);
        chk("R6 sec rise", 16'(pwm_sec[0]), 16'd1);

        // R7, R8, R9: mid-cycle period write, match pulses, edge-mode bottom
        do_reset();
        setup(10'd9, 10'd3, 10'd3, 10'd0, 4'd0, 4'b1001);
        wr(4'd0, 8'h01);
        wait_edges(2);
        wr(4'd4, 8'd4);  // lands on the third edge
        chk("R8 match masked", 16'(irq_match), 16'b001);
        wait_edges(1);
        chk("R8 match one clock", 16'(irq_match), 16'b000);
        wait_edges(5);
        chk("R7 old period kept", 16'(cnt_value), 16'd9);
        chk("R9 no early bottom", 16'(irq_bottom), 16'd0);
        wait_edges(1);
        chk("R3 wrap", 16'(cnt_value), 16'd0);
        chk("R9 bottom edge mode", 16'(irq_bottom), 16'd1);
        wait_edges(1);
        chk("R9 bottom one clock", 16'(irq_bottom), 16'd0);
        wait_edges(3);
        chk("R7 new period top", 16'(cnt_value), 16'd4);
        wait_edges(1);
        chk("R7 new period wrap", 16'(cnt_value), 16'd0);

        // R9: centre-mode bottom only on reaching zero downward
        do_reset();
        setup(10'd3, 10'd0, 10'd0, 10'd0, 4'd0, 4'b1000);
        wr(4'd0, 8'h03);
        wait_edges(4);
        chk("R4 reversal", 16'(cnt_value), 16'd2);
        chk("R9 none at top", 16'(irq_bottom), 16'd0);
        wait_edges(2);
        chk("R4 bottom", 16'(cnt_value), 16'd0);
        chk("R9 bottom centre", 16'(irq_bottom), 16'd1);

        // R2: code 15 follows the external tick; R10: stop clears counter
        do_reset();
        setup(10'd9, 10'd2, 10'd0, 10'd0, 4'd0, 4'd0);
        wr(4'd0, 8'hF1);
        wait_edges(5);
        chk("R2 ext idle", 16'(cnt_value), 16'd0);
        ext_tick = 1'b1;
        wait_edges(3);
        ext_tick = 1'b0;
        chk("R2 ext steps", 16'(cnt_value), 16'd3);
        wr(4'd0, 8'hF0);
        chk("R10 before clear", 16'(cnt_value), 16'd3);
        wait_edges(1);
        chk("R10 cleared", 16'(cnt_value), 16'd0);
        chk("R5 stopped low", 16'({pwm_pri, pwm_sec}), 16'd0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule